// File: doc/BRIEF.md
# Interrupt Redirection Register Block

This block holds the programmable state of an interrupt router: a small device ID, a fixed version word, and one 64-bit redirection entry for each interrupt input pin. Software reaches all of it through a pair of 32-bit bus registers. An 8-bit select register names an internal register, and a data window register reads or writes the named register. Each table entry is reached as two 32-bit halves, chosen by bit 0 of the select value.

Every entry's fields are driven out on flat vectors, so delivery and destination logic elsewhere in the chip can read them without going through the bus. That logic reports the remote-IRR status of a level-triggered pin back through a dedicated update port. Software cannot alter that status bit by writing to the window. Delivery status also stays clear, because a window write always forces it to zero.

Bus accesses are single-cycle strobes. Writes take effect at the clock edge that samples them. Read data is registered and appears one edge after the read strobe.

Top module: `irr_regblock`

## Requirements
- R1: After reset, every entry reads as 0x00010000 in its low half (mask bit 16 set) and 0 in its high half. The select register and the ID read as zero. On the exports, `ent_mask` is all ones and every other field is zero.
- R2: Only `bus_addr[7:0]` is decoded. Offset 0x00 is the select register and offset 0x10 is the data window. A read of any other offset returns 0, and a write to any other offset changes no state.
- R3: The select register holds 8 bits. A read of offset 0x00 returns them in bits 7:0, with zeros above. A write stores `bus_wdata[7:0]`.
- R4: With select 0x01, a window read returns NPINS-1 in bits 23:16, the VERSION parameter in bits 7:0 and zeros elsewhere. Window writes with this select change nothing.
- R5: With select 0x00, a window write stores `bus_wdata[27:24]` as the 4-bit ID. A window read returns the ID in bits 27:24 and zeros elsewhere. Select 0x02 reads the same value, and window writes with select 0x02 are ignored.
- R6: Select 0x10+2*i addresses the low half (bits 31:0) of entry i, and select 0x11+2*i addresses its high half (bits 63:32). No other entry is affected.
- R7: A window access is out of range when its select value decodes to an index of NPINS or more, or when the select is 0x03 through 0x0F. Such a read returns 0 and such a write is dropped.
- R8: A high-half write replaces bits 63:32 of the entry and leaves bits 31:0 unchanged.
- R9: A low-half write stores `bus_wdata` into bits 31:0, except that bit 12 (delivery status) is forced to 0 and bit 14 (remote IRR) keeps its previous value.
- R10: The exports follow this layout:
  - `ent_vector` comes from bits 7:0.
  - `ent_dlv_mode` comes from bits 10:8.
  - `ent_dest_mode` comes from bit 11.
  - `ent_dlv_status` comes from bit 12.
  - `ent_polarity` comes from bit 13.
  - `ent_remote_irr` comes from bit 14.
  - `ent_trig_level` comes from bit 15.
  - `ent_mask` comes from bit 16.
  - `ent_dest_id` comes from bits 63:56.
  - Pin i occupies slice i of each vector.
- R11: When `irr_upd_valid` is high, bit 14 of entry `irr_upd_idx` takes the value of `irr_upd_value` at the next edge. This update wins over a low-half write to the same entry in the same cycle. An index of NPINS or more is ignored.
- R12: `bus_rdata` updates at the edge that samples a read (`bus_en` high and `bus_we` low). At all other times it holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; only bits 7:0 are decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irr_upd_valid | input | 1 | Remote-IRR update strobe |
| irr_upd_idx | input | IDX_W | Pin index of the update |
| irr_upd_value | input | 1 | New remote-IRR value |
| ent_vector | output | NPINS*8 | Vector field per pin |
| ent_dlv_mode | output | NPINS*3 | Delivery mode per pin |
| ent_dest_mode | output | NPINS | Destination mode per pin |
| ent_dlv_status | output | NPINS | Delivery status per pin |
| ent_polarity | output | NPINS | Input polarity per pin |
| ent_remote_irr | output | NPINS | Remote IRR per pin |
| ent_trig_level | output | NPINS | Trigger mode per pin (1 = level) |
| ent_mask | output | NPINS | Mask per pin |
| ent_dest_id | output | NPINS*8 | Destination ID per pin |

## Verification
A write, or a remote-IRR update, changes state at the rising edge that samples it. The entry exports therefore show the new value one edge after the strobe. Read data is registered, so the value for a read strobe appears on `bus_rdata` one edge later and is held until the next read.

The bench drives every strobe at a falling edge and removes it at the following falling edge. It samples `bus_rdata` and the exports at that same falling edge, half a cycle after the edge that updated them. A read issued right after a write therefore already sees the written value.

// File: rtl/irr_pkg.sv
package irr_pkg;

  // Bus offsets, compared against the low address byte
  localparam logic [7:0] OFF_SELECT = 8'h00;
  localparam logic [7:0] OFF_WINDOW = 8'h10;

  // Select values with a fixed meaning
  localparam logic [7:0] SEL_ID       = 8'h00;
  localparam logic [7:0] SEL_VERSION  = 8'h01;
  localparam logic [7:0] SEL_ARB      = 8'h02;
  localparam logic [7:0] SEL_TBL_BASE = 8'h10;

  // Bit positions inside a 64-bit entry
  localparam int B_VEC_LO   = 0;
  localparam int B_DLV_LO   = 8;
  localparam int B_DMODE    = 11;
  localparam int B_DSTAT    = 12;
  localparam int B_POL      = 13;
  localparam int B_RIRR     = 14;
  localparam int B_TRIG     = 15;
  localparam int B_MASK     = 16;
  localparam int B_DEST_LO  = 56;

  localparam logic [63:0] ENTRY_RESET = 64'h0000_0000_0001_0000;

  typedef enum logic [2:0] {
    WK_NONE,
    WK_ID,
    WK_ARB,
    WK_VER,
    WK_TBL
  } win_kind_t;

endpackage

// File: rtl/irr_ctrl_regs.sv
module irr_ctrl_regs
  import irr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NPINS  = 48,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [7:0]        sel_q,
  output logic [3:0]        id_q,
  output logic              off_sel,
  output logic              off_win,
  output win_kind_t         win_kind,
  output logic [IDX_W-1:0]  tbl_idx,
  output logic              tbl_hi,
  output logic              tbl_wr_lo,
  output logic              tbl_wr_hi
);

  logic       sel_wr;
  logic       win_wr;
  logic [8:0] rel;
  logic       tbl_ok;
  logic [7:0] sel_d;
  logic [3:0] id_d;
  logic       id_en;

  always_comb begin
    off_sel = (bus_addr[7:0] == OFF_SELECT);
    off_win = (bus_addr[7:0] == OFF_WINDOW);
    sel_wr  = bus_en && bus_we && off_sel;
    win_wr  = bus_en && bus_we && off_win;
  end

  // Table decode: index = (select - base) >> 1, half = select bit 0
  always_comb begin
    rel     = {1'b0, sel_q} - {1'b0, SEL_TBL_BASE};
    tbl_ok  = !rel[8] && (int'(rel[7:1]) < NPINS);
    tbl_idx = IDX_W'(rel[7:1]);
    tbl_hi  = sel_q[0];
  end

  always_comb begin
    unique case (sel_q)
      SEL_ID:      win_kind = WK_ID;
      SEL_ARB:     win_kind = WK_ARB;
      SEL_VERSION: win_kind = WK_VER;
      default:     win_kind = tbl_ok ? WK_TBL : WK_NONE;
    endcase
  end

  always_comb begin
    tbl_wr_lo = win_wr && (win_kind == WK_TBL) && !tbl_hi;
    tbl_wr_hi = win_wr && (win_kind == WK_TBL) && tbl_hi;
    id_en     = win_wr && (win_kind == WK_ID);
    id_d      = bus_wdata[27:24];
    sel_d     = bus_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_wr) begin
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= '0;
    end else if (id_en) begin
      id_q <= id_d;
    end
  end

  // R2
  stray_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && !off_sel && !off_win) |=> ($stable(sel_q) && $stable(id_q)));

  // R4
  ver_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && (win_kind == WK_VER)) |=> $stable(id_q));

  // R5
  arb_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && (win_kind == WK_ARB)) |=> $stable(id_q));

  // R7
  tbl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tbl_wr_lo, tbl_wr_hi}));

endmodule

// File: rtl/irr_entry.sv
module irr_entry
  import irr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        irr_upd,
  input  logic        irr_val,
  output logic [63:0] q
);

  logic [63:0] d;
  logic        en;

  always_comb begin
    d = q;
    if (wr_hi) begin
      d[63:32] = wdata;
    end
    if (wr_lo) begin
      d[31:0]    = wdata;
      d[B_DSTAT] = 1'b0;
      d[B_RIRR]  = q[B_RIRR];
    end
    if (irr_upd) begin
      d[B_RIRR] = irr_val;
    end
    en = wr_lo || wr_hi || irr_upd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= ENTRY_RESET;
    end else if (en) begin
      q <= d;
    end
  end

  // R9
  lo_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (q[B_DSTAT] == 1'b0));

  // R9
  lo_irr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !irr_upd) |=> (q[B_RIRR] == $past(q[B_RIRR])));

  // R8
  hi_keep_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo && !irr_upd) |=> (q[31:0] == $past(q[31:0])));

  // R11
  irr_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irr_upd |=> (q[B_RIRR] == $past(irr_val)));

endmodule

// File: rtl/irr_readback.sv
module irr_readback
  import irr_pkg::*;
#(
  parameter int          NPINS   = 48,
  parameter int          IDX_W   = 6,
  parameter logic [7:0]  VERSION = 8'h11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd,
  input  logic                   off_sel,
  input  logic                   off_win,
  input  win_kind_t              win_kind,
  input  logic [IDX_W-1:0]       tbl_idx,
  input  logic                   tbl_hi,
  input  logic [7:0]             sel_q,
  input  logic [3:0]             id_q,
  input  logic [NPINS-1:0][63:0] tbl_q,
  output logic [31:0]            rdata
);

  localparam logic [7:0] LAST_PIN = 8'(NPINS - 1);

  logic [63:0] picked;
  logic [31:0] win_val;
  logic [31:0] rd_val;

  always_comb begin
    picked = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (tbl_idx == IDX_W'(i)) begin
        picked = tbl_q[i];
      end
    end
  end

  always_comb begin
    unique case (win_kind)
      WK_VER:        win_val = {8'h00, LAST_PIN, 8'h00, VERSION};
      WK_ID, WK_ARB: win_val = {4'h0, id_q, 24'h000000};
      WK_TBL:        win_val = tbl_hi ? picked[63:32] : picked[31:0];
      default:       win_val = '0;
    endcase
  end

  always_comb begin
    if (off_sel) begin
      rd_val = {24'h000000, sel_q};
    end else if (off_win) begin
      rd_val = win_val;
    end else begin
      rd_val = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= rd_val;
    end
  end

  // R2
  stray_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !off_sel && !off_win) |=> (rdata == 32'h0));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));

endmodule

// File: rtl/irr_regblock.sv
module irr_regblock
  import irr_pkg::*;
#(
  parameter int         ADDR_W  = 32,
  parameter int         NPINS   = 48,
  parameter logic [7:0] VERSION = 8'h11,
  localparam int        IDX_W   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic                 irr_upd_valid,
  input  logic [IDX_W-1:0]     irr_upd_idx,
  input  logic                 irr_upd_value,
  output logic [NPINS*8-1:0]   ent_vector,
  output logic [NPINS*3-1:0]   ent_dlv_mode,
  output logic [NPINS-1:0]     ent_dest_mode,
  output logic [NPINS-1:0]     ent_dlv_status,
  output logic [NPINS-1:0]     ent_polarity,
  output logic [NPINS-1:0]     ent_remote_irr,
  output logic [NPINS-1:0]     ent_trig_level,
  output logic [NPINS-1:0]     ent_mask,
  output logic [NPINS*8-1:0]   ent_dest_id
);

  logic [7:0]             sel_q;
  logic [3:0]             id_q;
  logic                   off_sel;
  logic                   off_win;
  win_kind_t              win_kind;
  logic [IDX_W-1:0]       tbl_idx;
  logic                   tbl_hi;
  logic                   tbl_wr_lo;
  logic                   tbl_wr_hi;
  logic                   rd;
  logic [NPINS-1:0][63:0] tbl_q;

  assign rd = bus_en && !bus_we;

  irr_ctrl_regs #(
    .ADDR_W (ADDR_W),
    .NPINS  (NPINS),
    .IDX_W  (IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sel_q     (sel_q),
    .id_q      (id_q),
    .off_sel   (off_sel),
    .off_win   (off_win),
    .win_kind  (win_kind),
    .tbl_idx   (tbl_idx),
    .tbl_hi    (tbl_hi),
    .tbl_wr_lo (tbl_wr_lo),
    .tbl_wr_hi (tbl_wr_hi)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic hit;
    logic upd;

    assign hit = (tbl_idx == IDX_W'(g));
    assign upd = irr_upd_valid && (irr_upd_idx == IDX_W'(g));

    irr_entry u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo   (tbl_wr_lo && hit),
      .wr_hi   (tbl_wr_hi && hit),
      .wdata   (bus_wdata),
      .irr_upd (upd),
      .irr_val (irr_upd_value),
      .q       (tbl_q[g])
    );

    assign ent_vector[g*8 +: 8]   = tbl_q[g][B_VEC_LO +: 8];
    assign ent_dlv_mode[g*3 +: 3] = tbl_q[g][B_DLV_LO +: 3];
    assign ent_dest_mode[g]       = tbl_q[g][B_DMODE];
    assign ent_dlv_status[g]      = tbl_q[g][B_DSTAT];
    assign ent_polarity[g]        = tbl_q[g][B_POL];
    assign ent_remote_irr[g]      = tbl_q[g][B_RIRR];
    assign ent_trig_level[g]      = tbl_q[g][B_TRIG];
    assign ent_mask[g]            = tbl_q[g][B_MASK];
    assign ent_dest_id[g*8 +: 8]  = tbl_q[g][B_DEST_LO +: 8];
  end

  irr_readback #(
    .NPINS   (NPINS),
    .IDX_W   (IDX_W),
    .VERSION (VERSION)
  ) u_readback (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (rd),
    .off_sel  (off_sel),
    .off_win  (off_win),
    .win_kind (win_kind),
    .tbl_idx  (tbl_idx),
    .tbl_hi   (tbl_hi),
    .sel_q    (sel_q),
    .id_q     (id_q),
    .tbl_q    (tbl_q),
    .rdata    (bus_rdata)
  );

  // R11
  irr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irr_upd_valid && (int'(irr_upd_idx) >= NPINS)) |=> $stable(ent_remote_irr));

endmodule

// File: tb/test_irr_regblock.sv
module test_irr_regblock;

  localparam int NP  = 48;
  localparam int IW  = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_en = 1'b0;
  logic              bus_we = 1'b0;
  logic [31:0]       bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              irr_upd_valid = 1'b0;
  logic [IW-1:0]     irr_upd_idx = '0;
  logic              irr_upd_value = 1'b0;
  logic [NP*8-1:0]   ent_vector;
  logic [NP*3-1:0]   ent_dlv_mode;
  logic [NP-1:0]     ent_dest_mode;
  logic [NP-1:0]     ent_dlv_status;
  logic [NP-1:0]     ent_polarity;
  logic [NP-1:0]     ent_remote_irr;
  logic [NP-1:0]     ent_trig_level;
  logic [NP-1:0]     ent_mask;
  logic [NP*8-1:0]   ent_dest_id;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  always #4 clk = ~clk;

  irr_regblock #(.ADDR_W(32), .NPINS(NP), .VERSION(8'h11)) i_irr_regblock (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_en         (bus_en),
    .bus_we         (bus_we),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .irr_upd_valid  (irr_upd_valid),
    .irr_upd_idx    (irr_upd_idx),
    .irr_upd_value  (irr_upd_value),
    .ent_vector     (ent_vector),
    .ent_dlv_mode   (ent_dlv_mode),
    .ent_dest_mode  (ent_dest_mode),
    .ent_dlv_status (ent_dlv_status),
    .ent_polarity   (ent_polarity),
    .ent_remote_irr (ent_remote_irr),
    .ent_trig_level (ent_trig_level),
    .ent_mask       (ent_mask),
    .ent_dest_id    (ent_dest_id)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic win_read(input logic [7:0] sel, output logic [31:0] d);
    bus_write(32'h00, {24'h0, sel});
    bus_read(32'h10, d);
  endtask

  task automatic win_write(input logic [7:0] sel, input logic [31:0] d);
    bus_write(32'h00, {24'h0, sel});
    bus_write(32'h10, d);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    bus_read(32'h00, r);       check("R1 select", r, 0);
    win_read(8'h00, r);        check("R1 id", r, 0);
    win_read(8'h1A, r);        check("R1 entry5 low", r, 32'h0001_0000);
    win_read(8'h1B, r);        check("R1 entry5 high", r, 0);
    check("R1 mask export", ent_mask, {NP{1'b1}});
    check("R1 vector export", ent_vector[63:0], 0);
    check("R1 irr export", ent_remote_irr, 0);
  endtask

  task automatic t_decode();
    logic [31:0] r;
    bus_write(32'h0000_0100, 32'h0000_0023);
    bus_read(32'h0000_0F00, r); check("R2 upper addr bits ignored", r, 32'h23);
    check("R3 select readback", r, 32'h23);
    bus_write(32'h20, 32'h55);
    bus_read(32'h00, r);        check("R2 stray write ignored", r, 32'h23);
    bus_read(32'h20, r);        check("R2 stray read zero", r, 0);
    bus_write(32'h00, 32'hFFFF_FF9C);
    bus_read(32'h00, r);        check("R3 only 8 bits", r, 32'h9C);
  endtask

  task automatic t_version();
    logic [31:0] r;
    win_read(8'h01, r);         check("R4 version", r, 32'h002F_0011);
    bus_write(32'h10, 32'hFFFF_FFFF);
    bus_read(32'h10, r);        check("R4 write ignored", r, 32'h002F_0011);
  endtask

  task automatic t_id();
    logic [31:0] r;
    win_write(8'h00, 32'hA5FF_FFFF);
    bus_read(32'h10, r);        check("R5 id store", r, 32'h0500_0000);
    win_read(8'h02, r);         check("R5 arb id read", r, 32'h0500_0000);
    bus_write(32'h10, 32'h0F00_0000);
    win_read(8'h00, r);         check("R5 arb write ignored", r, 32'h0500_0000);
  endtask

  task automatic t_table();
    logic [31:0] r;
    win_write(8'h16, 32'hFFFF_FFFF);
    bus_read(32'h10, r);        check("R9 low write", r, 32'hFFFF_AFFF);
    check("R10 vector", ent_vector[3*8 +: 8], 8'hFF);
    check("R10 dlv mode", ent_dlv_mode[3*3 +: 3], 3'h7);
    check("R10 fields", {ent_dest_mode[3], ent_dlv_status[3], ent_polarity[3],
                         ent_remote_irr[3], ent_trig_level[3], ent_mask[3]}, 6'b101011);
    win_write(8'h17, 32'hAB00_1234);
    bus_read(32'h10, r);        check("R6 high half", r, 32'hAB00_1234);
    check("R10 dest id", ent_dest_id[3*8 +: 8], 8'hAB);
    win_read(8'h16, r);         check("R8 low kept", r, 32'hFFFF_AFFF);
    win_read(8'h14, r);         check("R6 neighbour 2", r, 32'h0001_0000);
    win_read(8'h18, r);         check("R6 neighbour 4", r, 32'h0001_0000);
  endtask

  task automatic t_irr();
    logic [31:0] r;
    @(negedge clk);
    irr_upd_valid = 1'b1; irr_upd_idx = 6'd3; irr_upd_value = 1'b1;
    @(negedge clk);
    irr_upd_valid = 1'b0;
    check("R11 set", ent_remote_irr[3], 1'b1);
    win_read(8'h16, r);         check("R11 readback", r, 32'hFFFF_EFFF);
    bus_write(32'h10, 32'h0);
    bus_read(32'h10, r);        check("R9 irr kept", r, 32'h0000_4000);
    @(negedge clk);
    irr_upd_valid = 1'b1; irr_upd_idx = 6'd3; irr_upd_value = 1'b0;
    @(negedge clk);
    irr_upd_valid = 1'b0;
    check("R11 clear", ent_remote_irr[3], 1'b0);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 32'h10; bus_wdata = 32'h0;
    irr_upd_valid = 1'b1; irr_upd_idx = 6'd3; irr_upd_value = 1'b1;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; irr_upd_valid = 1'b0;
    bus_read(32'h10, r);        check("R11 update wins", r, 32'h0000_4000);
    @(negedge clk);
    irr_upd_valid = 1'b1; irr_upd_idx = 6'd50; irr_upd_value = 1'b1;
    @(negedge clk);
    irr_upd_valid = 1'b0;
    check("R11 out of range", ent_remote_irr, {{(NP-4){1'b0}}, 4'b1000});
  endtask

  task automatic t_range();
    logic [31:0] r;
    win_write(8'h70, 32'h1234_5678);
    bus_read(32'h10, r);        check("R7 beyond table", r, 0);
    win_read(8'h05, r);         check("R7 gap select", r, 0);
    win_read(8'h6E, r);         check("R7 last pin in range", r, 32'h0001_0000);
    win_write(8'h6F, 32'h7700_0000);
    bus_read(32'h10, r);        check("R6 last pin high", r, 32'h7700_0000);
    win_read(8'h10, r);         check("R7 pin0 untouched", r, 32'h0001_0000);
    check("R7 vectors untouched", ent_vector[2*8 +: 8], 0);
  endtask

  task automatic t_latency();
    logic [31:0] r;
    bus_write(32'h00, 32'h42);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = 32'h00;
    @(negedge clk);
    bus_en = 1'b0;
    check("R12 one edge", bus_rdata, 32'h42);
    bus_write(32'h00, 32'h43);
    check("R12 hold on write", bus_rdata, 32'h42);
    repeat (3) @(negedge clk);
    check("R12 hold idle", bus_rdata, 32'h42);
    bus_read(32'h00, r);        check("R12 next read", r, 32'h43);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_decode();
    t_version();
    t_id();
    t_table();
    t_irr();
    t_range();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule